// File: doc/BRIEF.md
# Transmit Data Link FIFO Controller

This block sits between the processor and the framer on the transmit side of a serial data link. The processor pushes message bytes into a FIFO and marks the last byte of each message with an end-of-message flag. The framer takes bytes from the head one at a time, using a request strobe. Bit stuffing, flag generation and codeword serialization live in the framer. Their milestones come back to this block as single-cycle strobes.

The block watches five conditions:

- a request that finds the FIFO empty partway through a message (underrun);
- a write that finds the FIFO full (overflow);
- the fill level dropping below a programmable threshold;
- the closing flag starting after the end-of-message byte has left;
- a bit-oriented codeword finishing.

Each condition is edge-detected and latched into an 8-bit status word until a status read clears it. A per-bit enable mask combines the latched bits into one interrupt line. On an underrun the block also pulses an abort request to the framer. It then treats the next written byte as the start of a new message.

Top module: `tdl_fifo_ctrl`

## Requirements
- R1: Bytes leave in write order, each with its end-of-message flag. `rd_valid_o` is high exactly when at least one byte is stored. A `rd_req_i` while `rd_valid_o` is high removes the head byte at that clock edge.
- R2: A `rd_req_i` that finds the FIFO empty after a byte without end-of-message has left is an underrun. It sets status bit 3 and drives `abort_o` high for exactly the following cycle. The message is then closed, so the next byte written starts a fresh message.
- R3: A write while DEPTH bytes are stored is dropped without changing the contents, and it sets status bit 2.
- R4: Status bit 1 is set when the fill level becomes less than `near_thr_i` (the level was not below it in the previous cycle). A level already below the threshold when reset is released does not set the bit.
- R5: A `close_flag_i` strobe sets status bit 0 only when an end-of-message byte has left since the last such strobe. Otherwise it has no effect.
- R6: A `cw_done_i` strobe sets status bit 7.
- R7: Status bits stay set until a `stat_rd_i` cycle, after which they read 0. Bits 6 to 4 always read 0, and the whole word reads 0 after reset.
- R8: Only a low-to-high change of a source sets its bit. A source held high after a clearing read leaves the bit clear.
- R9: A source that rises in the same cycle as a clearing read leaves its bit set.
- R10: `irq_o` is high exactly when some status bit and the matching `irq_en_i` bit are both 1.
- R11: A `rd_req_i` on an empty FIFO outside a message does nothing: no status bit and no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Processor write strobe |
| wr_data_i | input | DW | Byte to store |
| wr_eom_i | input | 1 | Marks the written byte as the last one of its message |
| near_thr_i | input | $clog2(DEPTH+1) | Near-empty threshold |
| rd_req_i | input | 1 | Framer request for the head byte |
| rd_valid_o | output | 1 | FIFO holds at least one byte |
| rd_data_o | output | DW | Head byte |
| rd_eom_o | output | 1 | End-of-message flag of the head byte |
| abort_o | output | 1 | One-cycle abort request after an underrun |
| close_flag_i | input | 1 | Framer strobe: closing flag begins |
| cw_done_i | input | 1 | Framer strobe: codeword sent, a new one may be loaded |
| stat_rd_i | input | 1 | Status read strobe, clears the status word |
| irq_en_i | input | 8 | Per-bit interrupt enables |
| stat_o | output | 8 | Latched status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 8 and DW left at 8. At that depth a few writes fill the FIFO, so the overflow drop and the full-to-empty drain are quick to reach. The threshold of 3 puts the near-empty crossing inside a short message. A behavioural queue model predicts the head byte, the abort pulse, the status word and the interrupt on every clock. Directed steps add checks for:

- underrun followed by restart;
- a held codeword strobe across a clearing read;
- a rise that lands in the same cycle as a read;
- a closing flag with no message pending.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned NUM_EV = 5;
  // event vector index
  localparam int unsigned EV_MSG  = 0;
  localparam int unsigned EV_NEAR = 1;
  localparam int unsigned EV_OVF  = 2;
  localparam int unsigned EV_ERR  = 3;
  localparam int unsigned EV_CW   = 4;
  // status bit position of each event
  localparam int unsigned EV_POS [NUM_EV] = '{0, 1, 2, 3, 7};
endpackage

// File: rtl/tdl_fifo_store.sv
module tdl_fifo_store #(
  parameter  int unsigned DEPTH = 64,
  parameter  int unsigned WW    = 9,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [WW-1:0] word_i,
  input  logic          pop_i,
  output logic [WW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wptr_q] <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wptr_q <= nxt(wptr_q);
      if (pop_i)  rptr_q <= nxt(rptr_q);
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = mem[rptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/tdl_drain_ctrl.sv
module tdl_drain_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  input  logic empty_i,
  input  logic head_eom_i,
  input  logic close_flag_i,
  output logic pop_o,
  output logic underrun_o,
  output logic msg_sent_o,
  output logic abort_o,
  output logic msg_act_o,
  output logic msg_pend_o
);
  logic act_q, pend_q, abort_q;

  assign pop_o      = rd_req_i & ~empty_i;
  assign underrun_o = rd_req_i & empty_i & act_q;
  assign msg_sent_o = close_flag_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= underrun_o;
      // underrun closes the partial message; next byte starts fresh
      if (underrun_o)  act_q <= 1'b0;
      else if (pop_o)  act_q <= ~head_eom_i;
      if (pop_o && head_eom_i) pend_q <= 1'b1;
      else if (close_flag_i)   pend_q <= 1'b0;
    end
  end

  assign abort_o    = abort_q;
  assign msg_act_o  = act_q;
  assign msg_pend_o = pend_q;
endmodule

// File: rtl/tdl_irq_latch.sv
module tdl_irq_latch #(
  parameter int unsigned       N       = 5,
  parameter logic [N-1:0]      RST_SRC = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         clear_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic src_q, stat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q  <= RST_SRC[i];
        stat_q <= 1'b0;
      end else begin
        src_q  <= src_i[i];
        stat_q <= (stat_q & ~clear_i) | (src_i[i] & ~src_q);
      end
    end
    assign stat_o[i] = stat_q;
  end
endmodule

// File: rtl/tdl_fifo_ctrl.sv
module tdl_fifo_ctrl
  import tdl_pkg::*;
#(
  parameter  int unsigned DEPTH = 64,
  parameter  int unsigned DW    = 8,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              wr_eom_i,
  input  logic [CW-1:0]     near_thr_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_eom_o,
  output logic              abort_o,
  input  logic              close_flag_i,
  input  logic              cw_done_i,
  input  logic              stat_rd_i,
  input  logic [STAT_W-1:0] irq_en_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [DW:0]       head;
  logic [CW-1:0]     count;
  logic              full, empty, push, pop;
  logic              underrun, msg_sent, msg_act, msg_pend;
  logic [NUM_EV-1:0] ev_src, ev_stat;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign push  = wr_valid_i & ~full;

  tdl_fifo_store #(.DEPTH(DEPTH), .WW(DW + 1)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .word_i  ({wr_eom_i, wr_data_i}),
    .pop_i   (pop),
    .head_o  (head),
    .count_o (count)
  );

  tdl_drain_ctrl u_drain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_req_i     (rd_req_i),
    .empty_i      (empty),
    .head_eom_i   (head[DW]),
    .close_flag_i (close_flag_i),
    .pop_o        (pop),
    .underrun_o   (underrun),
    .msg_sent_o   (msg_sent),
    .abort_o      (abort_o),
    .msg_act_o    (msg_act),
    .msg_pend_o   (msg_pend)
  );

  always_comb begin
    ev_src          = '0;
    ev_src[EV_MSG]  = msg_sent;
    ev_src[EV_NEAR] = (count < near_thr_i);
    ev_src[EV_OVF]  = wr_valid_i & full;
    ev_src[EV_ERR]  = underrun;
    ev_src[EV_CW]   = cw_done_i;
  end

  // near-empty level at reset release must not count as an edge
  localparam logic [NUM_EV-1:0] RST_SRC = NUM_EV'(1) << EV_NEAR;

  tdl_irq_latch #(.N(NUM_EV), .RST_SRC(RST_SRC)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (ev_src),
    .clear_i (stat_rd_i),
    .stat_o  (ev_stat)
  );

  always_comb begin
    stat_o = '0;
    for (int i = 0; i < NUM_EV; i++) stat_o[EV_POS[i]] = ev_stat[i];
  end

  assign irq_o      = |(stat_o & irq_en_i);
  assign rd_valid_o = ~empty;
  assign rd_data_o  = head[DW-1:0];
  assign rd_eom_o   = head[DW];
endmodule

// File: rtl/tdl_fifo_ctrl_chk.sv
module tdl_fifo_ctrl_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          rd_req_i,
  input logic          rd_valid_o,
  input logic          abort_o,
  input logic [7:0]    stat_o,
  input logic          stat_rd_i,
  input logic          cw_done_i,
  input logic          close_flag_i,
  input logic          msg_act,
  input logic          msg_pend,
  input logic [CW-1:0] count
);
  assert_abort_after_underrun_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_valid_o && msg_act) |=> (abort_o && stat_o[3]));

  assert_abort_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && count == CW'(DEPTH) && !rd_req_i) |=> (count == CW'(DEPTH) && stat_o[2]));

  assert_msg_sent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_flag_i && msg_pend && !$past(close_flag_i)) |=> stat_o[0]);

  assert_read_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !cw_done_i && !close_flag_i && !wr_valid_i && !rd_req_i)
      |=> (stat_o[7] == 1'b0 && stat_o[3:2] == 2'b00 && stat_o[0] == 1'b0));

  assert_held_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && cw_done_i && $past(cw_done_i)) |=> !stat_o[7]);

  always @(posedge clk_i) begin
    if (rst_ni) assert_count_bound_R3: assert (count <= CW'(DEPTH));
  end
endmodule

bind tdl_fifo_ctrl tdl_fifo_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/sim_tdl_fifo_ctrl.sv
`timescale 1ns/1ps
module sim_tdl_fifo_ctrl;
  localparam int D  = 8;
  localparam int CW = $clog2(D + 1);

  logic clk = 0, rst_ni = 0;
  logic wr_valid = 0, wr_eom = 0, rd_req = 0, close_flag = 0, cw_done = 0, stat_rd = 0;
  logic [7:0] wr_data = 0, irq_en = 0;
  logic [CW-1:0] near_thr = 3;
  logic rd_valid, rd_eom, abort_w, irq;
  logic [7:0] rd_data, stat;

  always #2 clk = ~clk;

  tdl_fifo_ctrl #(.DEPTH(D), .DW(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_eom_i(wr_eom), .near_thr_i(near_thr), .rd_req_i(rd_req), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .rd_eom_o(rd_eom), .abort_o(abort_w), .close_flag_i(close_flag),
    .cw_done_i(cw_done), .stat_rd_i(stat_rd), .irq_en_i(irq_en), .stat_o(stat), .irq_o(irq));

  int n_chk = 0, n_fail = 0;
  logic [8:0] q[$];
  bit m_act = 0, m_pend = 0, m_abort = 0;
  bit [4:0] m_srcq = 5'b00010, m_ev = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_stat();
    return {m_ev[4], 3'b000, m_ev[3:0]};
  endfunction

  task automatic model_step();
    int sz = q.size();
    bit [4:0] src, rise;
    logic [8:0] w;
    bit popd = rd_req && sz > 0;
    bit und = rd_req && sz == 0 && m_act;
    src = {cw_done, und, wr_valid && sz == D, sz < int'(near_thr), close_flag && m_pend};
    rise = src & ~m_srcq;
    m_srcq = src;
    m_ev = (stat_rd ? 5'b0 : m_ev) | rise;
    if (close_flag) m_pend = 0;
    if (popd) begin
      w = q.pop_front();
      if (w[8]) m_pend = 1;
      m_act = !w[8];
    end
    if (und) m_act = 0;
    m_abort = und;
    if (wr_valid && sz < D) q.push_back({wr_eom, wr_data});
  endtask

  task automatic compare();
    chk(rd_valid == (q.size() > 0), "R1 valid", rd_valid, q.size() > 0);
    if (q.size() > 0) chk({rd_eom, rd_data} == q[0], "R1 head", {rd_eom, rd_data}, q[0]);
    chk(abort_w == m_abort, "R2 abort", abort_w, m_abort);
    chk(stat == m_stat(), "R7 status", stat, m_stat());
    chk(irq == |(m_stat() & irq_en), "R10 irq", irq, |(m_stat() & irq_en));
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    model_step();
    compare();
    wr_valid = 0; wr_eom = 0; rd_req = 0; close_flag = 0; cw_done = 0; stat_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr_byte(input logic [7:0] d, input bit e);
    wr_valid = 1; wr_data = d; wr_eom = e; cyc();
  endtask

  task automatic pop();
    rd_req = 1; cyc();
  endtask

  task automatic sread();
    stat_rd = 1; cyc();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    chk(stat == 8'h00, "R7 reset status", stat, 0);
    chk(!rd_valid && !abort_w && !irq, "R1 reset outputs", {rd_valid, abort_w, irq}, 0);
    idle(3);
    chk(stat[1] == 0, "R4 no fire at reset level", stat[1], 0);

    // message 1,2,3 with eom
    wr_byte(8'h01, 0); wr_byte(8'h02, 0); wr_byte(8'h03, 1);
    chk(rd_data == 8'h01 && !rd_eom, "R1 head first", rd_data, 1);
    pop();
    chk(rd_data == 8'h02, "R1 head second", rd_data, 2);
    pop();
    chk(rd_data == 8'h03 && rd_eom, "R1 head eom", {rd_eom, rd_data}, 9'h103);
    pop();
    idle(1);
    chk(stat[1] == 1, "R4 near-empty", stat[1], 1);
    close_flag = 1; cyc();
    chk(stat[0] == 1, "R5 msg sent", stat[0], 1);
    sread();
    chk(stat == 8'h00, "R7 read clear", stat, 0);
    close_flag = 1; cyc(); idle(1);
    chk(stat[0] == 0, "R5 no pending msg", stat[0], 0);

    // codeword, held source
    cw_done = 1; cyc();
    chk(stat[7] == 1, "R6 codeword", stat[7], 1);
    chk(stat[6:4] == 0, "R7 reserved", stat[6:4], 0);
    cw_done = 1; stat_rd = 1; cyc();
    chk(stat[7] == 0, "R8 held after clear", stat[7], 0);
    cw_done = 1; cyc();
    chk(stat[7] == 0, "R8 still held", stat[7], 0);
    idle(1);
    cw_done = 1; stat_rd = 1; cyc();
    chk(stat[7] == 1, "R9 rise with read", stat[7], 1);
    irq_en = 8'h80; idle(1);
    chk(irq == 1, "R10 enabled", irq, 1);
    irq_en = 8'h01; idle(1);
    chk(irq == 0, "R10 masked", irq, 0);
    irq_en = 8'hFF; sread();
    chk(irq == 0, "R10 cleared", irq, 0);

    // underrun
    wr_byte(8'h05, 0); wr_byte(8'h06, 0);
    pop(); pop(); pop();
    chk(stat[3] == 1 && abort_w == 1, "R2 underrun", {stat[3], abort_w}, 2'b11);
    idle(1);
    chk(abort_w == 0, "R2 abort one cycle", abort_w, 0);
    sread();
    pop(); idle(1);
    chk(stat[3] == 0 && abort_w == 0, "R11 idle request", {stat[3], abort_w}, 0);
    wr_byte(8'h07, 1);
    chk(rd_valid && rd_data == 8'h07, "R2 restart", rd_data, 7);
    pop();
    sread();

    // overflow
    for (int i = 0; i < D; i++) wr_byte(8'(8'h10 + i), i == D - 1);
    wr_byte(8'h99, 0);
    chk(stat[2] == 1, "R3 overflow flag", stat[2], 1);
    for (int i = 0; i < D; i++) begin
      chk(rd_data == 8'(8'h10 + i), "R3 contents kept", rd_data, 8'h10 + i);
      pop();
    end
    chk(rd_valid == 0, "R3 dropped byte absent", rd_valid, 0);
    idle(2);
    summary();
  end
endmodule